// File: doc/BRIEF.md
# SDRAM Bring-up and ECC Zero-Fill Sequencer

This block brings a local SDRAM module into service once its timing has been configured. It writes a fixed default word to the global SDRAM control register. If the module's presence-detect type byte reports an ECC part, it writes that word again with the ECC enable bit set. It then starts the controller's memory initialisation and polls the start bit, which the controller clears itself, until that bit drops or a cycle budget runs out.

With ECC enabled, every 32-bit word of the module must be given a known value before first use, so that reads do not raise check-bit errors. The sequencer walks the whole module and writes zero to each word through a small paged window. It sets the window page register each time the walk enters a new page. After the writes that fill a page, it writes a commit strobe to a general control register. Three level outputs report progress: busy while running, done on success, error on timeout.

Top module: `sdram_init_seq`

## Requirements
- R1: During and right after reset, busy, done, error, regWrEn and memWrEn are all low.
- R2: After a start pulse while idle, the first register write goes to control offset CTRL_OFS (default 0x088) with data 0x022259F1. Busy is high from the cycle after start until done or error rises.
- R3: When spdType equals 0x02, the second register write goes to CTRL_OFS with data 0x022359F1 (bit 16 set). For any other spdType, no such write occurs.
- R4: The next control write clears bit 18 and sets bit 19: 0x022A59F1 without ECC, 0x022B59F1 with ECC.
- R5: After that write the block polls initBusy. It proceeds in the first poll cycle in which initBusy is low. If initBusy is still high in poll cycle TMO_LIMIT-1 (counting from 0), error rises and no further writes occur.
- R6: Without ECC, done rises directly after a successful poll and no memory write occurs.
- R7: With ECC and sizeMb > 0, each word of the sizeMb*UNIT_BYTES byte range is written exactly once, with memWrData = 0. Within one page burst, memOffset rises by one word per write.
- R8: Before the first write into each page, one write goes to offset 0x00C carrying the page index (byte address / WIN_BYTES, unshifted). This happens only when a new page is entered.
- R9: After the last write of each page burst comes one write of 0x01 to offset 0x484, before any other register write.
- R10: With ECC and sizeMb = 0, done rises after the poll with no window, commit or memory writes.
- R11: A start pulse while busy is ignored. done and error hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| spdType | input | 8 | Presence-detect memory type byte |
| sizeMb | input | SIZE_W | Module size in UNIT_BYTES units |
| initBusy | input | 1 | Read-back of controller start bit 19 |
| regWrEn | output | 1 | Register write strobe |
| regAddr | output | ADDR_W | Register byte offset |
| regWrData | output | 32 | Register write data |
| memWrEn | output | 1 | Window memory write strobe |
| memOffset | output | WIN_LG | Word offset inside the window |
| memWrData | output | 32 | Window write data (zero) |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Initialisation timed out |

## Verification
Several properties are checked on every cycle. busy, done and error are never high together. Memory writes happen only while busy, with memOffset advancing by one word inside a burst. Every burst ends with a commit write of 0x01 to 0x484. A start-bit write is followed by busy. error holds until a new start. The following can only be shown by the bench's scenarios, which compare a logged register and memory image against values computed from the requirements: the exact order and data of the control writes, the page index values, exact once-only coverage of the memory, and the cycle at which polling gives up.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  localparam logic [31:0] CTRL_DEFAULT = 32'h0222_59F1;
  localparam int ECC_BIT   = 16;
  localparam int SEL_BIT   = 18;
  localparam int KICK_BIT  = 19;
  localparam logic [31:0] COMMIT_VAL = 32'h1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WR_DEF, ST_WR_ECC, ST_WR_KICK, ST_POLL,
    ST_PAGE, ST_FILL, ST_COMMIT, ST_DONE, ST_FAIL
  } state_t;

  typedef struct packed {
    logic load;
    logic clrTmo;
    logic incTmo;
    logic incWord;
  } strb_t;
endpackage

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int SIZE_W     = 10,
  parameter int WIN_BYTES  = 32768,
  parameter int UNIT_BYTES = 1048576,
  parameter int TMO_LIMIT  = 50000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [7:0]        spdType,
  input  logic [SIZE_W-1:0] sizeMb,
  output logic              eccOn,
  output logic              sizeNz,
  output logic              tmoHit,
  output logic              pageLast,
  output logic              lastWord,
  output logic              scrubEnd,
  output logic [31:0]       pageIdx,
  output logic [$clog2(WIN_BYTES)-3:0] wordOfs
);
  localparam int WIN_LG  = $clog2(WIN_BYTES) - 2;
  localparam int UNIT_LG = $clog2(UNIT_BYTES) - 2;
  localparam int CNT_W   = SIZE_W + UNIT_LG + 1;
  localparam int TMO_W   = $clog2(TMO_LIMIT + 1);

  logic [SIZE_W-1:0] sizeQ;
  logic [CNT_W-1:0]  wordCnt;
  logic [CNT_W-1:0]  totalWords;
  logic [TMO_W-1:0]  tmoCnt;

  assign totalWords = CNT_W'(sizeQ) << UNIT_LG;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eccOn   <= 1'b0;
      sizeQ   <= '0;
      wordCnt <= '0;
      tmoCnt  <= '0;
    end else begin
      if (strb.load) begin
        eccOn   <= (spdType == 8'h02);
        sizeQ   <= sizeMb;
        wordCnt <= '0;
      end else if (strb.incWord) begin
        wordCnt <= wordCnt + 1'b1;
      end
      if (strb.clrTmo)      tmoCnt <= '0;
      else if (strb.incTmo) tmoCnt <= tmoCnt + 1'b1;
    end
  end

  assign sizeNz   = (sizeQ != '0);
  assign tmoHit   = (tmoCnt == TMO_W'(TMO_LIMIT - 1));
  assign wordOfs  = wordCnt[WIN_LG-1:0];
  assign pageLast = &wordCnt[WIN_LG-1:0];
  assign lastWord = (wordCnt == totalWords - 1'b1);
  assign scrubEnd = (wordCnt == totalWords);
  assign pageIdx  = 32'(wordCnt >> WIN_LG);
endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 12'h088,
  parameter logic [ADDR_W-1:0] WIN_OFS    = 12'h00C,
  parameter logic [ADDR_W-1:0] COMMIT_OFS = 12'h484
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              initBusy,
  input  logic              eccOn,
  input  logic              sizeNz,
  input  logic              tmoHit,
  input  logic              pageLast,
  input  logic              lastWord,
  input  logic              scrubEnd,
  input  logic [31:0]       pageIdx,
  output strb_t             strb,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWrData,
  output logic              memWrEn,
  output logic              busy,
  output logic              done,
  output logic              error
);
  state_t state, nextState;
  logic [31:0] ctrlWord;
  logic        idleLike;

  assign ctrlWord = CTRL_DEFAULT | (32'(eccOn) << ECC_BIT);
  assign idleLike = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    regWrEn   = 1'b0;
    regAddr   = CTRL_OFS;
    regWrData = '0;
    memWrEn   = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = ST_WR_DEF;
        end
      end
      ST_WR_DEF: begin
        regWrEn   = 1'b1;
        regWrData = CTRL_DEFAULT;
        nextState = eccOn ? ST_WR_ECC : ST_WR_KICK;
      end
      ST_WR_ECC: begin
        regWrEn   = 1'b1;
        regWrData = ctrlWord;
        nextState = ST_WR_KICK;
      end
      ST_WR_KICK: begin
        regWrEn     = 1'b1;
        regWrData   = (ctrlWord & ~(32'h1 << SEL_BIT)) | (32'h1 << KICK_BIT);
        strb.clrTmo = 1'b1;
        nextState   = ST_POLL;
      end
      ST_POLL: begin
        strb.incTmo = 1'b1;
        if (!initBusy)   nextState = (eccOn && sizeNz) ? ST_PAGE : ST_DONE;
        else if (tmoHit) nextState = ST_FAIL;
      end
      ST_PAGE: begin
        regWrEn   = 1'b1;
        regAddr   = WIN_OFS;
        regWrData = pageIdx;
        nextState = ST_FILL;
      end
      ST_FILL: begin
        memWrEn      = 1'b1;
        strb.incWord = 1'b1;
        if (pageLast || lastWord) nextState = ST_COMMIT;
      end
      ST_COMMIT: begin
        regWrEn   = 1'b1;
        regAddr   = COMMIT_OFS;
        regWrData = COMMIT_VAL;
        nextState = scrubEnd ? ST_DONE : ST_PAGE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy  = !idleLike;
  assign done  = (state == ST_DONE);
  assign error = (state == ST_FAIL);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SIZE_W     = 10,
  parameter int WIN_BYTES  = 32768,
  parameter int UNIT_BYTES = 1048576,
  parameter int TMO_LIMIT  = 50000000,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 12'h088,
  parameter logic [ADDR_W-1:0] WIN_OFS    = 12'h00C,
  parameter logic [ADDR_W-1:0] COMMIT_OFS = 12'h484,
  localparam int WIN_LG = $clog2(WIN_BYTES) - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        spdType,
  input  logic [SIZE_W-1:0] sizeMb,
  input  logic              initBusy,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWrData,
  output logic              memWrEn,
  output logic [WIN_LG-1:0] memOffset,
  output logic [31:0]       memWrData,
  output logic              busy,
  output logic              done,
  output logic              error
);
  strb_t       strb;
  logic        eccOn, sizeNz, tmoHit, pageLast, lastWord, scrubEnd;
  logic [31:0] pageIdx;

  sdram_init_dp #(
    .SIZE_W(SIZE_W), .WIN_BYTES(WIN_BYTES),
    .UNIT_BYTES(UNIT_BYTES), .TMO_LIMIT(TMO_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .spdType(spdType), .sizeMb(sizeMb),
    .eccOn(eccOn), .sizeNz(sizeNz), .tmoHit(tmoHit), .pageLast(pageLast),
    .lastWord(lastWord), .scrubEnd(scrubEnd), .pageIdx(pageIdx),
    .wordOfs(memOffset)
  );

  sdram_init_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS),
    .WIN_OFS(WIN_OFS), .COMMIT_OFS(COMMIT_OFS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .initBusy(initBusy),
    .eccOn(eccOn), .sizeNz(sizeNz), .tmoHit(tmoHit), .pageLast(pageLast),
    .lastWord(lastWord), .scrubEnd(scrubEnd), .pageIdx(pageIdx),
    .strb(strb), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .memWrEn(memWrEn), .busy(busy), .done(done), .error(error)
  );

  assign memWrData = '0;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 12,
  parameter int WIN_LG = 13,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 12'h088,
  parameter logic [ADDR_W-1:0] COMMIT_OFS = 12'h484
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic              memWrEn,
  input logic [WIN_LG-1:0] memOffset
);
  // R2
  status_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done, error}));

  // R7
  mem_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy);

  // R7
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && $past(memWrEn) |-> memOffset == $past(memOffset) + 1'b1);

  // R9
  commit_after_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWrEn) |-> regWrEn && regAddr == COMMIT_OFS && regWrData == 32'h1);

  // R5
  kick_then_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == CTRL_OFS && regWrData[19] |=> busy && !regWrEn);

  // R11
  error_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    error && !start |=> error);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .WIN_LG(WIN_LG), .CTRL_OFS(CTRL_OFS), .COMMIT_OFS(COMMIT_OFS)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .error(error), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .memWrEn(memWrEn), .memOffset(memOffset)
);

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_BYTES  = 64;
  localparam int UNIT_BYTES = 256;
  localparam int TMO_LIMIT  = 20;
  localparam int WIN_WORDS  = WIN_BYTES / 4;
  localparam int UNIT_WORDS = UNIT_BYTES / 4;
  localparam int MEM_WORDS  = 256;
  localparam int LOG_MAX    = 64;

  typedef struct packed {
    logic [7:0] spd;
    logic [3:0] size;
    logic [7:0] dly;
    logic       expErr;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{spd: 8'h01, size: 4'd2, dly: 8'd5,  expErr: 1'b0},
    '{spd: 8'h02, size: 4'd1, dly: 8'd3,  expErr: 1'b0},
    '{spd: 8'h02, size: 4'd3, dly: 8'd19, expErr: 1'b0},
    '{spd: 8'h02, size: 4'd2, dly: 8'd20, expErr: 1'b1},
    '{spd: 8'h00, size: 4'd0, dly: 8'd1,  expErr: 1'b0},
    '{spd: 8'h02, size: 4'd0, dly: 8'd2,  expErr: 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  spdType = '0;
  logic [9:0]  sizeMb = '0;
  logic        initBusy;
  logic        regWrEn, memWrEn, busy, done, error;
  logic [11:0] regAddr;
  logic [31:0] regWrData, memWrData;
  logic [3:0]  memOffset;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(
    .WIN_BYTES(WIN_BYTES), .UNIT_BYTES(UNIT_BYTES), .TMO_LIMIT(TMO_LIMIT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .spdType(spdType), .sizeMb(sizeMb),
    .initBusy(initBusy), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memWrEn(memWrEn), .memOffset(memOffset),
    .memWrData(memWrData), .busy(busy), .done(done), .error(error)
  );

  // controller model: register log, self-clearing start bit, memory image
  logic        logClr = 1'b0;
  int          busyDly = 1;
  int          busyCnt;
  logic        busyBit;
  int          curPage;
  int          logN;
  logic [11:0] logA [LOG_MAX];
  logic [31:0] logD [LOG_MAX];
  int          hits [MEM_WORDS];
  int          memNonZero;
  int          memCount;

  assign initBusy = busyBit;

  always @(posedge clk) begin
    if (logClr) begin
      logN <= 0; memNonZero <= 0; memCount <= 0; curPage <= 0;
      busyBit <= 1'b0; busyCnt <= 0;
      for (int i = 0; i < MEM_WORDS; i++) hits[i] <= 0;
    end else begin
      if (busyBit) begin
        if (busyCnt == 1) busyBit <= 1'b0;
        busyCnt <= busyCnt - 1;
      end
      if (regWrEn) begin
        if (logN < LOG_MAX) begin
          logA[logN] <= regAddr;
          logD[logN] <= regWrData;
        end
        logN <= logN + 1;
        if (regAddr == 12'h088 && regWrData[19]) begin
          busyBit <= 1'b1;
          busyCnt <= busyDly;
        end
        if (regAddr == 12'h00C) curPage <= int'(regWrData);
      end
      if (memWrEn) begin
        memCount <= memCount + 1;
        if (memWrData != 0) memNonZero <= memNonZero + 1;
        if (curPage * WIN_WORDS + int'(memOffset) < MEM_WORDS)
          hits[curPage * WIN_WORDS + int'(memOffset)] <= hits[curPage * WIN_WORDS + int'(memOffset)] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk); logClr = 1'b1;
    @(negedge clk); logClr = 1'b0;
  endtask

  // returns 0 ok, 1 done, 2 error, 3 hung
  task automatic runSeq(input vec_t v, input bit midStart, output int outcome);
    busyDly = int'(v.dly);
    clearLog();
    spdType = v.spd; sizeMb = 10'(v.size);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: busy from the cycle after start
    check(busy == 1'b1 && done == 1'b0, "R2", "busy after start", longint'(busy), 1);
    outcome = 3;
    for (int c = 0; c < 3000; c++) begin
      if (midStart && c == 30) begin
        spdType = 8'h00; sizeMb = 10'd1; start = 1'b1;
      end else start = 1'b0;
      if (done)  begin outcome = 1; break; end
      if (error) begin outcome = 2; break; end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic verifyRun(input vec_t v, input int outcome, input string tag);
    bit ecc;
    int expN, pages, total;
    logic [11:0] eA [LOG_MAX];
    logic [31:0] eD [LOG_MAX];
    logic [31:0] base;
    bit seqOk;
    int bad;
    ecc  = (v.spd == 8'h02);
    base = 32'h0222_59F1 | (ecc ? 32'h0001_0000 : 32'h0);
    expN = 0;
    eA[expN] = 12'h088; eD[expN] = 32'h0222_59F1; expN++;
    if (ecc) begin eA[expN] = 12'h088; eD[expN] = base; expN++; end
    eA[expN] = 12'h088; eD[expN] = (base & ~32'h0004_0000) | 32'h0008_0000; expN++;
    total = (ecc && !v.expErr) ? int'(v.size) * UNIT_WORDS : 0;
    pages = total / WIN_WORDS;
    for (int p = 0; p < pages; p++) begin
      eA[expN] = 12'h00C; eD[expN] = 32'(p);   expN++;
      eA[expN] = 12'h484; eD[expN] = 32'h1;    expN++;
    end
    // R5 / R6 / R10: outcome
    check(outcome == (v.expErr ? 2 : 1), v.expErr ? "R5" : "R6", {tag, " outcome"},
          outcome, v.expErr ? 2 : 1);
    // R2 R3 R4 R8 R9: register write sequence
    check(logN == expN, "R8", {tag, " reg write count"}, logN, expN);
    seqOk = 1'b1;
    for (int i = 0; i < expN && i < logN; i++) begin
      if (logA[i] != eA[i] || logD[i] != eD[i]) begin
        if (seqOk)
          $display("FAIL R3 %s write %0d actual=%0h:%0h expected=%0h:%0h",
                   tag, i, logA[i], logD[i], eA[i], eD[i]);
        seqOk = 1'b0;
      end
    end
    checks++;
    if (!seqOk) errors++;
    // R7: coverage exactly once, data zero
    bad = 0;
    for (int w = 0; w < MEM_WORDS; w++)
      if (hits[w] != ((w < total) ? 1 : 0)) bad++;
    check(bad == 0 && memCount == total, "R7", {tag, " words written once"}, memCount, total);
    check(memNonZero == 0, "R7", {tag, " zero data"}, memNonZero, 0);
  endtask

  initial begin
    int oc;
    // R1: reset state
    logClr = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !regWrEn && !memWrEn, "R1", "reset outputs",
          {busy, done, error, regWrEn, memWrEn}, 0);
    rstN = 1'b1;
    logClr = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error && !regWrEn && !memWrEn, "R1", "idle after reset",
          {busy, done, error, regWrEn, memWrEn}, 0);

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      runSeq(VECS[k], 1'b0, oc);
      verifyRun(VECS[k], oc, $sformatf("vec%0d", k));
    end

    // R11: start while busy is ignored (ECC run, second start requests no ECC)
    runSeq(VECS[2], 1'b1, oc);
    verifyRun(VECS[2], oc, "midstart");

    // R11: done holds and nothing more is written
    repeat (10) @(negedge clk);
    check(done == 1'b1 && !busy, "R11", "done held", longint'(done), 1);
    check(logN == 27, "R11", "no writes after done", logN, 27);

    // R11: error holds after timeout run
    runSeq(VECS[3], 1'b0, oc);
    repeat (10) @(negedge clk);
    check(error == 1'b1 && !done, "R11", "error held", longint'(error), 1);
    check(logN == 3, "R5", "no writes after timeout", logN, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule